// File: doc/BRIEF.md
# Shared-Level Transactional State Tracker

This block keeps a two-bit transactional tag for every block address on the shared cache or memory side of a hardware transactional memory. Private caches send it their transactional reads and writes. The block moves the tag through its four states and, when an access collides with transactional use by someone else, reports a conflict. Each conflict records the address in a small busy buffer and requests a software scan of every transaction log. The tracker keeps no owner identity and no reader tally. Coherence tells it, through one request bit, whether the requester already holds the block.

A block in the multiple-reader state is never cleared by reads or by commits, because the tracker cannot know when the last reader has left. The stale tag stays until a later conflict on that block starts a log scan. Software then reports the corrected state together with the busy slot it was given. The tracker writes that state and frees the slot in the same cycle. While a slot holds an address, every request to that address is stalled. Scan and cleanup therefore look atomic to all requesters, and requests to other addresses keep flowing.

Top module: `tx_shared_tracker`

## Requirements
- R1: After reset every block is Idle, the busy buffer is empty, `walk_req_valid` is 0 and `resp_valid` is 0.
- R2: Tag encoding is Idle=00, single reader=01, single writer=10, multiple readers=11. An accepted read of an Idle block makes it 01, an accepted write makes it 10, and neither is a conflict.
- R3: In state 01 a read with `req_own`=0 moves the block to 11 and a read with `req_own`=1 leaves it at 01. In state 10 any access with `req_own`=1 leaves it at 10. None of these is a conflict.
- R4: A write to a block in 01 or 11, or any access with `req_own`=0 to a block in 10, is a conflict. The tag is left unchanged, and the address takes the lowest-numbered free busy slot.
- R5: A block in 11 stays in 11 under any number of reads and is not cleared by any event other than a walk completion for its slot.
- R6: A request with `req_valid`=1 and `req_stall`=0 is accepted. Exactly one cycle later `resp_valid` is 1, and `resp_conflict` tells whether it was a conflict. A stalled request has no effect.
- R7: A request whose address is held in any busy slot (issued or not) is stalled combinationally in the same cycle.
- R8: When all busy slots are occupied, a request that would conflict is stalled rather than dropped. It is accepted once a slot frees. Non-conflicting requests to other addresses are not stalled.
- R9: While any busy slot holds an address not yet handed to software, `walk_req_valid` is 1 and `walk_req_addr`/`walk_req_slot` show the lowest-numbered such slot, held until `walk_req_ready` is 1 in a clock cycle.
- R10: `walk_done` with an issued slot number writes `walk_done_state` to that slot's block (value 11 is written as 00) and frees the slot in the same clock edge. A `walk_done` naming a slot that is empty or not yet issued is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transactional access present |
| req_write | input | 1 | 1 = transactional write, 0 = transactional read |
| req_own | input | 1 | Requester already holds the block transactionally |
| req_addr | input | ADDR_W | Block address |
| req_stall | output | 1 | Access not taken this cycle; retry |
| resp_valid | output | 1 | Result of the access accepted last cycle |
| resp_conflict | output | 1 | That access was a conflict |
| walk_req_valid | output | 1 | A log scan is requested |
| walk_req_addr | output | ADDR_W | Address the scan concerns |
| walk_req_slot | output | SLOT_W | Busy slot to quote on completion |
| walk_req_ready | input | 1 | Software takes the scan request |
| walk_done | input | 1 | A log scan has finished |
| walk_done_slot | input | SLOT_W | Slot of the finished scan |
| walk_done_state | input | 2 | Corrected tag for the block |

## Verification
The hardest situation to reach from the ports is a full busy buffer in which some slots are issued and others are still waiting. A conflicting request is held against it while a completion, a new scan grant and a harmless access to another address all arrive in the same cycle. A directed sequence fills every slot with conflicts on distinct addresses, then holds a fifth conflict and a non-conflicting access against it. It also sends a completion for an unissued slot before draining the buffer in order. A long seeded random phase then keeps addresses within eight blocks and grants or completes scans at random, so that stalls, reallocation of freed slots and stale multiple-reader tags recur often. A bench model checks every cycle.

// File: rtl/tx_trk_pkg.sv
`timescale 1ns/1ps
package tx_trk_pkg;

    typedef enum logic [1:0] {
        TS_IDLE     = 2'b00,
        TS_SOLO_RD  = 2'b01,
        TS_SOLO_WR  = 2'b10,
        TS_MULTI_RD = 2'b11
    } tstate_e;

    typedef struct packed {
        logic    conflict;
        tstate_e nxt;
    } step_t;

    // Tag transition for one accepted access; conflict leaves the tag as is.
    function automatic step_t tx_step(tstate_e cur, logic wr, logic own);
        step_t r;
        r.conflict = 1'b0;
        r.nxt      = cur;
        unique case (cur)
            TS_IDLE:     r.nxt = wr ? TS_SOLO_WR : TS_SOLO_RD;
            TS_SOLO_RD: begin
                if (wr)        r.conflict = 1'b1;
                else if (!own) r.nxt = TS_MULTI_RD;
            end
            TS_SOLO_WR: begin
                if (!own) r.conflict = 1'b1;
            end
            TS_MULTI_RD: begin
                if (wr) r.conflict = 1'b1;
            end
            default: r.nxt = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tx_state_table.sv
`timescale 1ns/1ps
module tx_state_table
    import tx_trk_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output tstate_e           rd_state,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  tstate_e           acc_state,
    input  logic              fix_we,
    input  logic [ADDR_W-1:0] fix_addr,
    input  tstate_e           fix_state
);
    localparam int NBLK = 1 << ADDR_W;

    logic [NBLK-1:0][1:0] st_d, st_q;

    assign rd_state = tstate_e'(st_q[rd_addr]);

    always_comb begin
        st_d = st_q;
        if (acc_we) st_d[acc_addr] = acc_state;
        // Completion of a log scan wins if both ever aim at one block.
        if (fix_we) st_d[fix_addr] = fix_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a stale multiple-reader tag survives every access-side write
    a_r5_multi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && tstate_e'(st_q[acc_addr]) == TS_MULTI_RD
         && !(fix_we && fix_addr == acc_addr))
        |=> tstate_e'(st_q[$past(acc_addr)]) == TS_MULTI_RD);

endmodule

// File: rtl/tx_busy_buf.sv
`timescale 1ns/1ps
module tx_busy_buf #(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic              full,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic              pend_vld,
    output logic [SLOT_W-1:0] pend_slot,
    output logic [ADDR_W-1:0] pend_addr,
    input  logic              issue,
    input  logic              done,
    input  logic [SLOT_W-1:0] done_slot,
    output logic              done_hit,
    output logic [ADDR_W-1:0] done_addr
);
    typedef struct packed {
        logic              vld;
        logic              iss;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    slot_t [SLOTS-1:0] s_d, s_q;
    logic [SLOT_W-1:0] free_slot;
    logic              found_free;

    always_comb begin
        s_d        = s_q;
        hit        = 1'b0;
        full       = 1'b1;
        found_free = 1'b0;
        free_slot  = '0;
        pend_vld   = 1'b0;
        pend_slot  = '0;
        pend_addr  = '0;
        done_hit   = 1'b0;
        done_addr  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (s_q[i].vld && s_q[i].addr == lk_addr) hit = 1'b1;
            if (!s_q[i].vld) begin
                full = 1'b0;
                if (!found_free) begin
                    found_free = 1'b1;
                    free_slot  = SLOT_W'(i);
                end
            end
            if (s_q[i].vld && !s_q[i].iss && !pend_vld) begin
                pend_vld  = 1'b1;
                pend_slot = SLOT_W'(i);
                pend_addr = s_q[i].addr;
            end
            if (done && done_slot == SLOT_W'(i) && s_q[i].vld && s_q[i].iss) begin
                done_hit  = 1'b1;
                done_addr = s_q[i].addr;
            end
        end
        if (issue && pend_vld) s_d[pend_slot].iss = 1'b1;
        if (done_hit)          s_d[done_slot]     = '0;
        if (alloc && found_free) begin
            s_d[free_slot].vld  = 1'b1;
            s_d[free_slot].iss  = 1'b0;
            s_d[free_slot].addr = alloc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: the access side never allocates into a full buffer
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);

    // R10: a completed slot is empty one edge later
    a_r10_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
        done_hit |=> !s_q[$past(done_slot)].vld);

    // R9: an ungranted scan request stays up
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld && !issue) |=> pend_vld);

endmodule

// File: rtl/tx_shared_tracker.sv
`timescale 1ns/1ps
module tx_shared_tracker
    import tx_trk_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SLOTS  = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_own,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_stall,
    output logic              resp_valid,
    output logic              resp_conflict,
    output logic              walk_req_valid,
    output logic [ADDR_W-1:0] walk_req_addr,
    output logic [SLOT_W-1:0] walk_req_slot,
    input  logic              walk_req_ready,
    input  logic              walk_done,
    input  logic [SLOT_W-1:0] walk_done_slot,
    input  logic [1:0]        walk_done_state
);
    typedef struct packed {
        logic rv;
        logic rc;
    } resp_t;

    resp_t             r_d, r_q;
    tstate_e           cur_state;
    step_t             stp;
    logic              busy_hit, busy_full;
    logic              accept, acc_we, alloc, issue;
    logic              done_hit;
    logic [ADDR_W-1:0] done_addr;
    tstate_e           fix_state;

    always_comb begin
        stp       = tx_step(cur_state, req_write, req_own);
        req_stall = req_valid && (busy_hit || (stp.conflict && busy_full));
        accept    = req_valid && !req_stall;
        acc_we    = accept && !stp.conflict;
        alloc     = accept && stp.conflict;
        issue     = walk_req_valid && walk_req_ready;
        fix_state = (walk_done_state == 2'b11) ? TS_IDLE : tstate_e'(walk_done_state);
        r_d.rv    = accept;
        r_d.rc    = accept && stp.conflict;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign resp_valid    = r_q.rv;
    assign resp_conflict = r_q.rc;

    tx_state_table #(.ADDR_W(ADDR_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (req_addr),
        .rd_state  (cur_state),
        .acc_we    (acc_we),
        .acc_addr  (req_addr),
        .acc_state (stp.nxt),
        .fix_we    (done_hit),
        .fix_addr  (done_addr),
        .fix_state (fix_state)
    );

    tx_busy_buf #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr    (req_addr),
        .hit        (busy_hit),
        .full       (busy_full),
        .alloc      (alloc),
        .alloc_addr (req_addr),
        .pend_vld   (walk_req_valid),
        .pend_slot  (walk_req_slot),
        .pend_addr  (walk_req_addr),
        .issue      (issue),
        .done       (walk_done),
        .done_slot  (walk_done_slot),
        .done_hit   (done_hit),
        .done_addr  (done_addr)
    );

    // R6: a response only follows an accepted request
    a_r6_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(req_valid) && !$past(req_stall)));

    // R4: a conflict response always comes with a scan request or busy slot in use
    a_r4_conflict_tracked: assert property (@(posedge clk) disable iff (!rst_n)
        resp_conflict |-> (walk_req_valid || $past(walk_req_ready)));

endmodule

// File: tb/tx_shared_tracker_tb.sv
`timescale 1ns/1ps
module tx_shared_tracker_tb;
    localparam int AW = 4;
    localparam int NS = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_own = 0;
    logic [AW-1:0] req_addr = '0;
    logic req_stall, resp_valid, resp_conflict, walk_req_valid;
    logic [AW-1:0] walk_req_addr;
    logic [SW-1:0] walk_req_slot;
    logic walk_req_ready = 0, walk_done = 0;
    logic [SW-1:0] walk_done_slot = '0;
    logic [1:0] walk_done_state = '0;

    always #2.5 clk = ~clk;

    tx_shared_tracker #(.ADDR_W(AW), .SLOTS(NS)) u_dut (.*);

    int errors = 0, checks = 0;
    int st [16];
    bit fresh [16];
    bit bv [NS], bi [NS];
    int ba [NS];
    bit e_rv = 0, e_rc = 0;
    string e_tag = "R6";

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected tag step from R2..R4
    function automatic void mstep(input int s, input bit w, input bit o,
                                  output int ns, output bit c);
        ns = s; c = 0;
        case (s)
            0: ns = w ? 2 : 1;
            1: if (w) c = 1; else if (!o) ns = 3;
            2: if (!o) c = 1;
            default: if (w) c = 1;
        endcase
    endfunction

    function automatic string tag_of(int s, bit fr, bit c);
        if (fr)     return "R10";
        if (c)      return "R4";
        if (s == 0) return "R2";
        if (s == 3) return "R5";
        return "R3";
    endfunction

    task automatic cyc(bit v, bit w, bit o, int a, bit rdy, bit dn, int ds, int dst);
        int ns, pslot, fslot;
        bit c, hit, full, exp_stall, acc, pv;
        @(negedge clk);
        chk("R6 resp_valid", resp_valid, e_rv);
        if (e_rv) chk({e_tag, " resp_conflict"}, resp_conflict, e_rc);
        req_valid = v; req_write = w; req_own = o; req_addr = AW'(a);
        walk_req_ready = rdy; walk_done = dn; walk_done_slot = SW'(ds);
        walk_done_state = 2'(dst);
        #1;
        hit = 0; full = 1; fslot = -1; pv = 0; pslot = 0;
        for (int i = 0; i < NS; i++) begin
            if (bv[i] && ba[i] == a) hit = 1;
            if (!bv[i]) begin full = 0; if (fslot < 0) fslot = i; end
            if (bv[i] && !bi[i] && !pv) begin pv = 1; pslot = i; end
        end
        mstep(st[a], w, o, ns, c);
        exp_stall = v && (hit || (c && full));
        chk(hit ? "R7 req_stall" : "R8 req_stall", req_stall, exp_stall);
        chk("R9 walk_req_valid", walk_req_valid, pv);
        if (pv) begin
            chk("R9 walk_req_slot", walk_req_slot, pslot);
            chk("R9 walk_req_addr", walk_req_addr, ba[pslot]);
        end
        acc = v && !exp_stall;
        e_rv = acc; e_rc = acc && c; e_tag = tag_of(st[a], fresh[a], c);
        if (pv && rdy) bi[pslot] = 1;
        if (dn && bv[ds] && bi[ds] && !(pv && rdy && pslot == ds)) begin
            st[ba[ds]] = (dst == 3) ? 0 : dst;
            fresh[ba[ds]] = 1;
            bv[ds] = 0; bi[ds] = 0;
        end
        if (acc) begin
            if (c) begin bv[fslot] = 1; bi[fslot] = 0; ba[fslot] = a; end
            else st[a] = ns;
            fresh[a] = 0;
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned r;
        for (int i = 0; i < 16; i++) begin st[i] = 0; fresh[i] = 0; end
        for (int i = 0; i < NS; i++) begin bv[i] = 0; bi[i] = 0; ba[i] = 0; end
        r = $urandom(32'd20251);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 walk_req_valid", walk_req_valid, 0);
        chk("R1 resp_valid", resp_valid, 0);
        chk("R1 req_stall idle", req_stall, 0);

        // R2/R3/R5 basic transitions
        cyc(1, 0, 0, 1, 0, 0, 0, 0);  // R2 idle read -> 01
        cyc(1, 0, 0, 1, 0, 0, 0, 0);  // R3 other reader -> 11
        cyc(1, 0, 1, 1, 0, 0, 0, 0);  // R5 stays 11
        cyc(1, 0, 0, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 2, 0, 0, 0, 0);  // R2 idle write -> 10
        cyc(1, 1, 1, 2, 0, 0, 0, 0);  // R3 holder rewrite
        cyc(1, 0, 0, 2, 0, 0, 0, 0);  // R4 conflict, slot0
        cyc(1, 0, 0, 2, 0, 0, 0, 0);  // R7 stalled
        cyc(1, 0, 0, 2, 1, 0, 0, 0);  // R9 grant, still stalled
        cyc(0, 0, 0, 0, 0, 1, 0, 1);  // R10 done -> 01
        cyc(1, 0, 0, 2, 0, 0, 0, 0);  // R10 read sees 01 -> 11
        cyc(1, 1, 0, 1, 0, 0, 0, 0);  // R4 write on stale 11, slot0
        // fill the buffer (R8)
        cyc(1, 1, 0, 3, 0, 0, 0, 0);
        cyc(1, 1, 0, 4, 0, 0, 0, 0);
        cyc(1, 1, 0, 5, 0, 0, 0, 0);
        cyc(1, 1, 0, 6, 0, 0, 0, 0);
        cyc(1, 0, 0, 3, 0, 0, 0, 0);
        cyc(1, 0, 0, 4, 0, 0, 0, 0);
        cyc(1, 0, 0, 5, 0, 0, 0, 0);  // slots 0..3 busy
        cyc(1, 0, 0, 6, 0, 0, 0, 0);  // R8 conflict stalled
        cyc(1, 0, 0, 7, 0, 0, 0, 0);  // R8 harmless access proceeds
        cyc(1, 0, 0, 6, 0, 1, 2, 0);  // R10 done on unissued slot ignored
        for (int k = 0; k < NS; k++) cyc(1, 0, 0, 6, 1, 0, 0, 0);
        for (int k = 0; k < NS; k++) cyc(1, 0, 0, 6, 0, 1, k, 3);
        cyc(1, 0, 0, 6, 0, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0, 0);  // R10 block 1 cleared to 00
        idle(2);

        // seeded random phase
        for (int k = 0; k < 6000; k++) begin
            cyc(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
                $urandom % 8, ($urandom % 3) == 0, ($urandom % 3) == 0,
                $urandom % NS, $urandom % 4);
        end
        for (int k = 0; k < 12; k++) cyc(0, 0, 0, 0, 1, 1, k % NS, 0);
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule